// File: doc/BRIEF.md
# DDR SDRAM Refresh Timing Monitor

This block is a synthesizable protocol checker that sits beside a DDR SDRAM controller. It watches the clock-enable line, the decoded command and the bank address, and it raises sticky error flags when the controller breaks the refresh rules. It counts the clocks since the last REFRESH and the REFRESH commands issued in the current refresh round.

Operation has two phases. After reset the round count is full, so the monitor starts in the operational phase. The first REFRESH restarts the round at one and opens a startup phase. During that phase only NOOP and REFRESH are legal. Once the round count is full again, the operational phase enforces three rules: the maximum refresh interval, the minimum delay from REFRESH to ACTIVATE, and a ban on mode-register and calibration commands. A bank-range check is also applied to commands that carry a bank address.

The errors stay set until the next reset, so a long test only needs to read them at the end. The running clock count can be watched at any time.

Top module: `ddr_refresh_monitor`

## Requirements
- R1: The `cmd` encoding is 0 NOOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 MODE-SET, 7 ZQ-CAL. Outside reset, a cycle with `cke` low sets `err[0]`. Such a cycle is not counted as a REFRESH, whatever `cmd` holds.
- R2: Reset is synchronous. While `rst` is high, the cycle clears `err` and fills the round count, so `startup_done` reads 1 after the edge. The clock counter still advances during reset.
- R3: `since_ref` reads 0 in the cycle after a REFRESH that is accepted with `cke` high. Every other cycle adds one to it. It saturates at its all-ones value.
- R4: An accepted REFRESH sets the round count to 1 if the count was full (NREF). Otherwise the REFRESH adds one to the count. `startup_done` is 1 exactly when the count equals NREF.
- R5: While `startup_done` is 0, any command other than NOOP or REFRESH with `cke` high sets `err[1]`.
- R6: While `startup_done` is 1, a non-REFRESH cycle with `cke` high in which `since_ref` is at least TREFI-1 sets `err[2]`. That is, the interval has reached TREFI clocks.
- R7: While `startup_done` is 1, an ACTIVATE in which `since_ref` is below TRFC-1 sets `err[3]`. An ACTIVATE placed k cycles after a REFRESH is legal only when k is at least TRFC.
- R8: While `startup_done` is 1, a MODE-SET or ZQ-CAL command with `cke` high sets `err[4]`. The same command during startup sets `err[1]` instead.
- R9: While `startup_done` is 1, an ACTIVATE, READ, WRITE or PRECHARGE whose `bank` is NBANKS or higher sets `err[5]`.
- R10: Each `err` bit changes in the cycle after its violation and stays set until a reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable seen on the memory bus |
| cmd | input | 3 | Decoded command code |
| bank | input | BAW | Bank address of the command |
| err | output | 6 | Sticky violation flags: cke, startup, interval, activate delay, mode/ZQ, bank |
| startup_done | output | 1 | Round count full (operational phase) |
| since_ref | output | CW | Clocks since the last accepted REFRESH |

## Verification
If the clock counter holds a wrong value, `since_ref` differs from the model one cycle later. The error shows on the port itself, long before any interval flag would fire.

A wrong round count shows in `startup_done` at the REFRESH that makes it disagree. It also shows one cycle after the next non-NOOP command, which sets the wrong one of `err[1]` or the operational flags.

Because the flags are sticky, a spurious set is never masked by later traffic. Every scenario therefore starts from a reset so that each flag is attributed to one stimulus.

// File: rtl/ddr_refresh_monitor.sv
module ddr_refresh_monitor #(
  parameter int NREF   = 8,
  parameter int TREFI  = 3120,
  parameter int TRFC   = 52,
  parameter int CW     = 12,
  parameter int NBANKS = 8,
  parameter int BAW    = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cke,
  input  logic [2:0]     cmd,
  input  logic [BAW-1:0] bank,
  output logic [5:0]     err,
  output logic           startup_done,
  output logic [CW-1:0]  since_ref
);
  localparam int RW = $clog2(NREF + 1);
  localparam logic [RW-1:0] FULL = RW'(NREF);
  localparam logic [CW:0] REFI_LIM = (CW+1)'(TREFI - 1);
  localparam logic [CW:0] RFC_LIM  = (CW+1)'(TRFC - 1);
  localparam logic [BAW:0] NB = (BAW+1)'(NBANKS);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_ZQ = 3'd7;

  logic [RW-1:0] issued;
  logic [CW-1:0] since = '0;
  logic [5:0]    err_q;
  logic [5:0]    hit;

  wire full   = (issued == FULL);
  wire live   = !rst && cke;
  wire is_ref = (cmd == C_REF);
  wire oper   = live && full && !is_ref;
  wire strt   = live && !full && !is_ref;
  wire banked = (cmd == C_ACT) || (cmd == C_RD) || (cmd == C_WR) || (cmd == C_PRE);
  wire [CW-1:0] since_inc = (&since) ? since : since + 1'b1;

  always_comb begin
    hit    = '0;
    hit[0] = !rst && !cke;
    hit[1] = strt && (cmd != C_NOP);
    hit[2] = oper && ({1'b0, since} >= REFI_LIM);
    hit[3] = oper && (cmd == C_ACT) && ({1'b0, since} < RFC_LIM);
    hit[4] = oper && ((cmd == C_MRS) || (cmd == C_ZQ));
    hit[5] = oper && banked && ({1'b0, bank} >= NB);
  end

  always_ff @(posedge clk) begin
    since <= (live && is_ref) ? '0 : since_inc;
    if (rst) begin
      issued <= FULL;
      err_q  <= '0;
    end else begin
      err_q <= err_q | hit;
      if (live && is_ref) issued <= full ? RW'(1) : issued + 1'b1;
    end
  end

  assign err          = err_q;
  assign startup_done = full;
  assign since_ref    = since;
endmodule

// File: rtl/ddr_refresh_monitor_chk.sv
module ddr_refresh_monitor_chk #(
  parameter int TRFC = 52,
  parameter int CW   = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cke,
  input logic [2:0]    cmd,
  input logic [5:0]    err,
  input logic          startup_done,
  input logic [CW-1:0] since_ref
);
  p_reset_r2: assert property (@(posedge clk) rst |=> (startup_done && err == 6'd0));

  p_cke_r1: assert property (@(posedge clk) disable iff (rst) !cke |=> err[0]);

  p_ref_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd == 3'd5) |=> since_ref == '0);

  p_count_r3: assert property (@(posedge clk) disable iff (rst)
    (!(cke && cmd == 3'd5) && since_ref != '1) |=> since_ref == CW'($past(since_ref) + 1'b1));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err & $past(err)) == $past(err)));

  p_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (cke && startup_done && (cmd == 3'd6 || cmd == 3'd7)) |=> err[4]);

  p_act_r7: assert property (@(posedge clk) disable iff (rst)
    (cke && startup_done && cmd == 3'd1 && {1'b0, since_ref} < (CW+1)'(TRFC - 1)) |=> err[3]);

  p_startup_r5: assert property (@(posedge clk) disable iff (rst)
    (cke && !startup_done && cmd != 3'd0 && cmd != 3'd5) |=> err[1]);
endmodule

bind ddr_refresh_monitor ddr_refresh_monitor_chk #(.TRFC(TRFC), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .err(err),
  .startup_done(startup_done), .since_ref(since_ref)
);

// File: tb/ddr_refresh_monitor_test.sv
module ddr_refresh_monitor_test;
  localparam int NREF = 4, TREFI = 40, TRFC = 6, CW = 8, NBANKS = 6, BAW = 3;

  logic clk = 0, rst = 1, cke = 1;
  logic [2:0] cmd = 0;
  logic [BAW-1:0] bank = 0;
  logic [5:0] err;
  logic startup_done;
  logic [CW-1:0] since_ref;

  ddr_refresh_monitor #(.NREF(NREF), .TREFI(TREFI), .TRFC(TRFC), .CW(CW),
    .NBANKS(NBANKS), .BAW(BAW)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank(bank),
    .err(err), .startup_done(startup_done), .since_ref(since_ref));

  always #10 clk = ~clk;

  int m_issued = NREF, m_since = 0, errors = 0, checks = 0;
  logic [5:0] m_err = 0;
  bit done = 0;
  string tag [6] = '{"R1", "R5", "R6", "R7", "R8", "R9"};

  task automatic model();
    int maxv = (1 << CW) - 1;
    int nxt = (m_since == maxv) ? m_since : m_since + 1;
    bit full = (m_issued == NREF);
    if (rst) begin
      m_issued = NREF; m_err = 0; m_since = nxt;
    end else if (!cke) begin
      m_err[0] = 1; m_since = nxt;
    end else if (cmd == 5) begin
      m_since = 0; m_issued = full ? 1 : m_issued + 1;
    end else if (!full) begin
      if (cmd != 0) m_err[1] = 1;
      m_since = nxt;
    end else begin
      if (m_since >= TREFI - 1) m_err[2] = 1;
      if (cmd == 1 && m_since < TRFC - 1) m_err[3] = 1;
      if (cmd == 6 || cmd == 7) m_err[4] = 1;
      if (cmd >= 1 && cmd <= 4 && bank >= NBANKS) m_err[5] = 1;
      m_since = nxt;
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (err[i] !== m_err[i]) begin
        errors++;
        $display("FAIL %s (sticky R10) err[%0d]=%b expected %b at %0t", tag[i], i, err[i], m_err[i], $time);
      end
    end
    checks++;
    if (startup_done !== (m_issued == NREF)) begin
      errors++;
      $display("FAIL R4/R2 startup_done=%b expected %b at %0t", startup_done, m_issued == NREF, $time);
    end
    checks++;
    if (since_ref !== CW'(m_since)) begin
      errors++;
      $display("FAIL R3 since_ref=%0d expected %0d at %0t", since_ref, m_since, $time);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic [2:0] cm, input logic [BAW-1:0] b);
    @(negedge clk);
    compare();
    rst = r; cke = c; cmd = cm; bank = b;
    model();
  endtask

  task automatic rs(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0);
  endtask

  task automatic go(input logic [2:0] cm, input logic [BAW-1:0] b);
    step(0, 1, cm, b);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) go(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    model();
    rs(4);                                 // R2 reset state
    nops(3); go(1, 0); nops(2);            // R7 ACT long after reset is legal
    go(5, 0); nops(1); go(2, 0); nops(2);  // R4 restart, R5 READ in startup
    rs(2);
    for (int i = 0; i < NREF; i++) begin go(5, 0); go(0, 0); end
    nops(1); go(1, 2); nops(2);            // R7 ACT too soon
    rs(2);
    for (int i = 0; i < NREF; i++) go(5, 0);
    nops(TRFC - 1); go(1, 1); go(3, 5); go(4, 6); nops(2);  // R7 boundary, R9
    rs(2); go(6, 0); nops(2);              // R8 mode-set
    rs(2); go(7, 0); nops(2);              // R8 ZQ
    rs(2); step(0, 0, 0, 0); nops(2);      // R1 cke low
    rs(2); nops(3); step(0, 0, 5, 0); nops(3);  // R1 refresh with cke low ignored
    rs(2); go(5, 0); for (int i = 0; i < NREF - 1; i++) go(5, 0);
    nops(TREFI - 2); go(5, 0); nops(2);    // R6 just in time, restarts round R4
    for (int i = 0; i < NREF - 1; i++) go(5, 0);
    nops(TREFI + 2);                       // R6 interval overrun
    rs(300);                               // R3 saturation during reset
    go(5, 0); go(6, 0); nops(2);           // R8 vs R5 in startup
    rs(1); nops(1);
    finish_run();
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end
endmodule